// File: doc/BRIEF.md
# Fetch Alignment Penalty Calculator

This block works out how many stall cycles a front end loses because of where an instruction sits inside an aligned fetch block. Code is fetched in blocks of eight dwords, which is 32 bytes. A descriptor comes in for each decoded instruction. It carries the instruction's dword address, its size (one or two dwords), whether it is a branch, whether that branch is conditional, whether it was taken, whether it jumps backward, and the dword address of its target.

Three placement rules can each charge whole penalties of a fixed number of cycles:

- A two-dword instruction is charged when it starts late in its block.
- A taken forward jump is charged when its target lands late in its block.
- A conditional branch that falls through is charged when it sits in the second half of its block.

The result for one descriptor is the sum of every rule that applies. The block also keeps a saturating running total of all charged cycles, which a synchronous clear can restart.

Descriptors enter and results leave through valid/ready handshakes. Exactly one result is produced per accepted descriptor, in order, through a single output register. A scheduler or performance model can use it to account fetch bubbles without decoding any instruction encodings.

Top module: `fetch_align_penalty`

## Requirements
- R1: While reset is held, and right after it, `out_valid` is 0, `out_total` is 0 and `in_ready` is 1.
- R2: One penalty equals `PENALTY_CYC` cycles (4 by default). A single-dword descriptor with no branch flag gets `out_penalty` 0.
- R3: The dword index is the address modulo 8. A two-dword instruction at index 0, 1 or 2 is free. At index 3 to 7 it costs one penalty.
- R4: A taken forward branch is charged on its target's index N. An index of 0 to 4 is free, and N from 5 to 7 costs N-4 penalties. A branch that is not taken gets no target charge.
- R5: A taken branch with the backward flag set gets no target charge, whatever the target index.
- R6: A conditional branch that is not taken is charged on its own index N. An index of 0 to 3 is free, and N from 4 to 7 costs N-3 penalties. A taken conditional branch gets no such charge.
- R7: When several rules apply to one descriptor, `out_penalty` is the sum of their charges.
- R8: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A descriptor is accepted when `in_valid` and `in_ready` are both high, and its result appears on the next cycle. While `out_valid` is high and `out_ready` is low, `out_penalty` holds steady. Results leave in acceptance order.
- R9: On the cycle a result appears, `out_total` has already grown by that result's `out_penalty`.
- R10: `out_total` stops at 2^`TOTAL_W`-1 and never wraps.
- R11: When `clear` is high at a clock edge, `out_total` becomes the penalty of a descriptor accepted at that same edge, or 0 if none is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of the running total |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be accepted |
| in_addr | input | ADDR_W | Dword address of the instruction |
| in_target | input | ADDR_W | Dword address of the branch target |
| in_two_dword | input | 1 | Instruction is two dwords long |
| in_branch | input | 1 | Instruction is a branch |
| in_cond | input | 1 | Branch is conditional |
| in_taken | input | 1 | Branch was taken |
| in_backward | input | 1 | Branch target lies behind the branch |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_penalty | output | PEN_W | Stall cycles charged to this descriptor |
| out_total | output | TOTAL_W | Saturating running total of charged cycles |

## Verification
The bench builds the block with `TOTAL_W` = 8 and `ADDR_W` = 12. The narrow total reaches its ceiling of 255 after about a dozen worst-case descriptors, so the saturating path and a clear that follows it both get exercised within a short run. The 12-bit addresses let random descriptors spread over many fetch blocks. They also land at every index, both as instruction addresses and as targets. The bench sweeps every index against each combination of rules, and random back-pressure covers the hold and ordering behaviour.

// File: rtl/fap_pkg.sv
package fap_pkg;

   // penalty units charged when an index reaches or passes the first charged slot
   function automatic int unsigned units_past(input int unsigned idx,
                                              input int unsigned first_charged);
      if (idx >= first_charged)
         return idx - first_charged + 1;
      return 0;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fap_rules.sv
module fap_rules
   import fap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned WIDE_FREE   = 3,
   parameter int unsigned TGT_FREE    = 5,
   parameter int unsigned COND_FREE   = 4,
   parameter int unsigned CNT_W       = 3
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] target,
   input  logic              two_dword,
   input  logic              branch,
   input  logic              cond,
   input  logic              taken,
   input  logic              backward,
   output logic [CNT_W-1:0]  units
);

   logic [IDX_W-1:0] own_idx;
   logic [IDX_W-1:0] tgt_idx;
   int unsigned      wide_u;
   int unsigned      tgt_u;
   int unsigned      fall_u;

   assign own_idx = addr[IDX_W-1:0];
   assign tgt_idx = target[IDX_W-1:0];

   always_comb begin
      wide_u = 0;
      tgt_u  = 0;
      fall_u = 0;
      if (two_dword && (int'(own_idx) >= WIDE_FREE))
         wide_u = 1;
      if (branch && taken && !backward)
         tgt_u = units_past(int'(tgt_idx), TGT_FREE);
      if (branch && cond && !taken)
         fall_u = units_past(int'(own_idx), COND_FREE);
      units = CNT_W'(wide_u + tgt_u + fall_u);
   end

endmodule

// File: rtl/fap_total.sv
module fap_total #(
   parameter int unsigned PEN_W    = 5,
   parameter int unsigned TOTAL_W  = 16,
   parameter bit          SATURATE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               add_en,
   input  logic [PEN_W-1:0]   add_val,
   output logic [TOTAL_W-1:0] total
);

   localparam int unsigned SUM_W = TOTAL_W + 1;
   localparam logic [TOTAL_W-1:0] TOP = {TOTAL_W{1'b1}};

   logic [TOTAL_W-1:0] inc;
   logic [TOTAL_W-1:0] next_total;
   logic [SUM_W-1:0]   sum;

   assign inc = add_en ? TOTAL_W'(add_val) : '0;
   assign sum = {1'b0, total} + {1'b0, inc};

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (clear)
               next_total = inc;
            else if (sum[TOTAL_W])
               next_total = TOP;
            else
               next_total = sum[TOTAL_W-1:0];
         end

         assert_no_decrease_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (total >= $past(total)));
      end else begin : g_wrap
         always_comb begin
            if (clear)
               next_total = inc;
            else
               next_total = sum[TOTAL_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         total <= '0;
      else
         total <= next_total;
   end

   assert_zero_keeps_total_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && (!add_en || add_val == '0)) |=> $stable(total));

   assert_clear_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !add_en) |=> (total == '0));

endmodule

// File: rtl/fap_slot.sv
module fap_slot #(
   parameter int unsigned W = 5
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         drain,
   output logic         full,
   output logic [W-1:0] val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         val  <= '0;
      end else if (load) begin
         full <= 1'b1;
         val  <= load_val;
      end else if (drain) begin
         full <= 1'b0;
      end
   end

   assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && !drain) |=> (full && $stable(val)));

endmodule

// File: rtl/fetch_align_penalty.sv
module fetch_align_penalty
   import fap_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned BLOCK_DWORDS = 8,
   parameter int unsigned WIDE_FREE    = 3,
   parameter int unsigned TGT_FREE     = 5,
   parameter int unsigned COND_FREE    = 4,
   parameter int unsigned PENALTY_CYC  = 4,
   parameter int unsigned TOTAL_W      = 16,
   parameter bit          SATURATE     = 1'b1,
   localparam int unsigned IDX_W       = $clog2(BLOCK_DWORDS),
   localparam int unsigned MAX_UNITS   = 1 + max_u(BLOCK_DWORDS - TGT_FREE,
                                                   BLOCK_DWORDS - COND_FREE),
   localparam int unsigned CNT_W       = $clog2(MAX_UNITS + 1),
   localparam int unsigned PEN_W       = $clog2(MAX_UNITS * PENALTY_CYC + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic [ADDR_W-1:0]  in_target,
   input  logic               in_two_dword,
   input  logic               in_branch,
   input  logic               in_cond,
   input  logic               in_taken,
   input  logic               in_backward,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [PEN_W-1:0]   out_penalty,
   output logic [TOTAL_W-1:0] out_total
);

   generate
      if ((BLOCK_DWORDS < 2) || ((BLOCK_DWORDS & (BLOCK_DWORDS - 1)) != 0)) begin : g_bad_block
         $error("BLOCK_DWORDS must be a power of two, at least 2");
      end
      if ((WIDE_FREE > BLOCK_DWORDS) || (TGT_FREE > BLOCK_DWORDS) ||
          (COND_FREE > BLOCK_DWORDS) || (TGT_FREE == 0) || (COND_FREE == 0)) begin : g_bad_free
         $error("free windows must lie inside one fetch block and be non-empty");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the block index");
      end
      if (TOTAL_W < PEN_W) begin : g_bad_total
         $error("TOTAL_W must hold at least one result");
      end
   endgenerate

   logic [CNT_W-1:0] units;
   logic [PEN_W-1:0] pen_cycles;
   logic             accept;

   fap_rules #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .WIDE_FREE (WIDE_FREE),
      .TGT_FREE  (TGT_FREE),
      .COND_FREE (COND_FREE),
      .CNT_W     (CNT_W)
   ) i_rules (
      .addr      (in_addr),
      .target    (in_target),
      .two_dword (in_two_dword),
      .branch    (in_branch),
      .cond      (in_cond),
      .taken     (in_taken),
      .backward  (in_backward),
      .units     (units)
   );

   assign pen_cycles = PEN_W'(int'(units) * PENALTY_CYC);
   assign in_ready   = !out_valid || out_ready;
   assign accept     = in_valid && in_ready;

   fap_slot #(
      .W (PEN_W)
   ) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (pen_cycles),
      .drain    (out_ready),
      .full     (out_valid),
      .val      (out_penalty)
   );

   fap_total #(
      .PEN_W    (PEN_W),
      .TOTAL_W  (TOTAL_W),
      .SATURATE (SATURATE)
   ) i_total (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .add_en  (accept),
      .add_val (pen_cycles),
      .total   (out_total)
   );

   assert_plain_free_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_two_dword && !in_branch) |=> (out_valid && out_penalty == '0));

   assert_backward_free_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_two_dword && in_branch && in_taken && in_backward) |=> (out_penalty == '0));

   assert_wide_early_free_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_two_dword && !in_branch && (int'(in_addr[IDX_W-1:0]) < WIDE_FREE))
      |=> (out_penalty == '0));

   assert_result_follows_accept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

endmodule

// File: tb/test_fetch_align_penalty.sv
module test_fetch_align_penalty;

   localparam int unsigned ADDR_W  = 12;
   localparam int unsigned TOTAL_W = 8;
   localparam int unsigned PEN_W   = 5;
   localparam int          TMAX    = (1 << TOTAL_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [ADDR_W-1:0] in_addr = '0;
   logic [ADDR_W-1:0] in_target = '0;
   logic              in_two_dword = 1'b0;
   logic              in_branch = 1'b0;
   logic              in_cond = 1'b0;
   logic              in_taken = 1'b0;
   logic              in_backward = 1'b0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [PEN_W-1:0]  out_penalty;
   logic [TOTAL_W-1:0] out_total;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fetch_align_penalty #(
      .ADDR_W  (ADDR_W),
      .TOTAL_W (TOTAL_W)
   ) i_fetch_align_penalty (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (clear),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_addr      (in_addr),
      .in_target    (in_target),
      .in_two_dword (in_two_dword),
      .in_branch    (in_branch),
      .in_cond      (in_cond),
      .in_taken     (in_taken),
      .in_backward  (in_backward),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_penalty  (out_penalty),
      .out_total    (out_total)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // reference model state
   bit    m_valid = 0;
   int    m_pen   = 0;
   string m_ptag  = "R2";
   int    m_total = 0;
   string m_ttag  = "R9";

   // behavioural penalty reference, returns cycles and the rule tag exercised
   task automatic ref_pen(input int addr, input int tgt, input bit two, input bit br,
                          input bit cnd, input bit tk, input bit bk,
                          output int cyc, output string tag);
      int ia, it, units, rules;
      ia = addr % 8;
      it = tgt % 8;
      units = 0;
      rules = 0;
      tag = "R2";
      if (two && ia >= 3) begin units += 1; rules++; tag = "R3"; end
      if (br && tk) begin
         if (bk) begin
            if (it >= 5) tag = "R5";
         end else if (it >= 5) begin
            units += it - 4; rules++; tag = "R4";
         end
      end
      if (br && cnd && !tk && ia >= 4) begin units += ia - 3; rules++; tag = "R6"; end
      if (rules > 1) tag = "R7";
      cyc = units * 4;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int    p;
      string t;
      bit    acc;
      bit    n_valid;
      int    n_pen, n_total;
      string n_ptag, n_ttag;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "out_total in reset", int'(out_total), 0);
      chk("R1", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;

      for (int cyc = 0; cyc < 3000; cyc++) begin
         @(negedge clk);
         // compare outputs against the model
         chk("R8", "in_ready", int'(in_ready), int'(!m_valid || out_ready));
         chk("R8", "out_valid", int'(out_valid), int'(m_valid));
         if (m_valid) chk(m_ptag, "out_penalty", int'(out_penalty), m_pen);
         chk(cyc == 0 ? "R1" : m_ttag, "out_total", int'(out_total), m_total);

         // drive new stimulus
         if (cyc < 512) begin
            // directed sweep: every index against each rule mix
            int idx, kind, base;
            idx  = cyc % 8;
            kind = (cyc / 8) % 8;
            base = int'($urandom_range(0, 500)) * 8;
            in_valid = 1'b1; out_ready = (cyc < 256) ? 1'b1 : 1'($urandom_range(0, 1));
            clear = 1'b0;
            in_addr = ADDR_W'(base + idx);
            in_target = ADDR_W'(base + ((idx + 3) % 8) + 64);
            in_two_dword = 0; in_branch = 0; in_cond = 0; in_taken = 0; in_backward = 0;
            case (kind)
               0: ;                                                          // R2
               1: in_two_dword = 1;                                          // R3
               2: begin in_branch = 1; in_taken = 1; in_target = ADDR_W'(base + 64 + idx); end // R4
               3: begin in_branch = 1; in_taken = 1; in_backward = 1; in_target = ADDR_W'(idx); end // R5
               4: begin in_branch = 1; in_cond = 1; end                      // R6
               5: begin in_branch = 1; in_cond = 1; in_taken = 1; end        // R6 taken
               6: begin in_two_dword = 1; in_branch = 1; in_cond = 1; end    // R7
               default: begin in_two_dword = 1; in_branch = 1; in_taken = 1; end // R7
            endcase
         end else if (cyc < 2600) begin
            // random traffic with back-pressure and clears
            in_valid     = ($urandom_range(0, 9) < 7);
            out_ready    = ($urandom_range(0, 9) < 6);
            clear        = ($urandom_range(0, 99) < 3);
            in_addr      = ADDR_W'($urandom);
            in_target    = ADDR_W'($urandom);
            in_two_dword = 1'($urandom_range(0, 1));
            in_branch    = 1'($urandom_range(0, 1));
            in_cond      = 1'($urandom_range(0, 1));
            in_taken     = 1'($urandom_range(0, 1));
            in_backward  = 1'($urandom_range(0, 1));
         end else begin
            // saturation run (R10), then a clear (R11)
            in_valid = 1'b1; out_ready = 1'b1;
            clear = (cyc == 2700 || cyc == 2750);
            in_valid = (cyc != 2750);
            in_addr = ADDR_W'(8 * 7 + 7);
            in_target = '0;
            in_two_dword = 1; in_branch = 1; in_cond = 1; in_taken = 0; in_backward = 0;
         end

         // model next state
         acc = in_valid && (!m_valid || out_ready);
         n_valid = m_valid; n_pen = m_pen; n_ptag = m_ptag;
         n_total = m_total; n_ttag = m_ttag;
         p = 0; t = "R2";
         if (acc) ref_pen(int'(in_addr), int'(in_target), in_two_dword, in_branch,
                          in_cond, in_taken, in_backward, p, t);
         if (acc) begin
            n_valid = 1; n_pen = p; n_ptag = t;
         end else if (out_ready) begin
            n_valid = 0;
         end
         if (clear) begin
            n_total = acc ? p : 0; n_ttag = "R11";
         end else if (acc) begin
            n_total = m_total + p; n_ttag = "R9";
            if (n_total > TMAX) begin n_total = TMAX; n_ttag = "R10"; end
            else if (m_total == TMAX) n_ttag = "R10";
         end

         @(posedge clk);
         m_valid = n_valid; m_pen = n_pen; m_ptag = n_ptag;
         m_total = n_total; m_ttag = n_ttag;
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule